// File: doc/BRIEF.md
# Three-Channel Fan PWM Generator

The block drives up to three fan control outputs with pulse-width modulated waveforms whose duty cycle software sets through a small byte-wide register port. One shared control byte holds a per-fan output enable, a 3-bit clock-select code that picks the divisor applied to the reference clock, a polarity flag and a minimum-duty flag. Each fan has a duty byte and two mode bytes: one for the choice between software and automatic control, one for smoothing. A separate byte keeps smart-mode and tachometer enables.

The divided clock advances one shared 2^PWM_W-step counter, and every fan compares that counter against its own duty value. Only software control is built. The automatic curve, smoothing, minimum duty, smart mode and tachometer bits are stored and read back but do not change any waveform. Duty and clock-select changes are taken over only where a period ends, so a reprogram never cuts a pulse short.

Top module: `fanpwm_top`

## Requirements
- R1: After reset every register reads 0x00, and every output sits at the high level, which is the inactive level for the reset polarity (active low).
- R2: Register map, with addr[3:2] selecting a slot. Slot 0: addr 0x0 is the control byte (bits 2:0 enable fans 1..3, bit 3 minimum-duty flag, bits 6:4 clock-select code, bit 7 polarity), fully read back. Addr 0x1 keeps bits 2:0 (smart mode) and 6:4 (tachometer) and reads the other bits as 0. Slot n (fan n, 1..3): offset 0 is the duty byte, offset 1 keeps only bit 7 (1 = automatic control), and offset 2 keeps only bit 7 (smoothing). Every other address reads 0.
- R3: One output period lasts 2^PWM_W base ticks (256 by default). A base tick is one reference clock divided by the divisor that the clock-select code chooses.
- R4: With duty value D, an enabled fan in software mode is active for exactly D base ticks of every period. D = 0 keeps it inactive for the whole period.
- R5: With polarity bit 1 the active level is high; with 0 it is low.
- R6: A fan whose enable bit is 0 drives the inactive level, starting from the clock edge that writes the bit.
- R7: A fan whose automatic-control bit is 1 drives the inactive level.
- R8: Clock-select divisors are: code 0 gives 1, codes 1 and 2 give 2, code 3 gives 6, code 4 gives 8, code 5 gives 16, code 6 gives 32, and code 7 gives SLOW_DIV (default 940, about 51 kHz from 48 MHz).
- R9: A new duty value or clock-select code takes effect only at the boundary between two periods. The period running when it is written finishes with the old values.
- R10: The minimum-duty flag, the smoothing bits and the smart-mode and tachometer bits have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational from addr) |
| pwm_o | output | NUM_FANS | Fan PWM outputs |

## Verification
A latched duty value that is wrong, or taken over at the wrong time, changes the number of active ticks in a period. It shows up within one period of the error: the bench counts active cycles over windows exactly one period long. A stuck or wrongly reloaded divisor scales every count by the wrong factor, so each clock-select code is checked by its own measurement. A boundary that comes too early shows up within a few dozen cycles as a pulse in the middle of a period, right after a duty rewrite. A wrong enable, mode or polarity decode shows at the port on the next clock.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

   localparam int REG_W  = 8;
   localparam int ADDR_W = 4;

   // shared control byte, bit positions are part of the register contract
   typedef struct packed {
      logic       pol;       // 1: active high
      logic [2:0] clk_sel;   // divisor code
      logic       min_duty;  // stored only
      logic [2:0] fan_en;    // bit n-1 enables fan n
   } ctrl_t;

   // divisor applied to the reference clock for a clock-select code
   function automatic int unsigned div_for_code(input logic [2:0] code,
                                                input int unsigned slow_div);
      case (code)
         3'd0:    return 1;
         3'd1,
         3'd2:    return 2;
         3'd3:    return 6;
         3'd4:    return 8;
         3'd5:    return 16;
         3'd6:    return 32;
         default: return slow_div;
      endcase
   endfunction

endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
   import fanpwm_pkg::*;
#(
   parameter int NUM_FANS = 3,
   parameter int PWM_W    = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [REG_W-1:0]               wdata,
   output logic [REG_W-1:0]               rdata,
   output logic                           pol,
   output logic [2:0]                     clk_sel,
   output logic [NUM_FANS-1:0]            fan_en,
   output logic [NUM_FANS-1:0]            auto_md,
   output logic [NUM_FANS-1:0][PWM_W-1:0] duty
);

   localparam logic [REG_W-1:0] MAIN_MASK = 8'h77;

   ctrl_t                           ctrl_q;
   logic [REG_W-1:0]                main_q;
   logic [NUM_FANS-1:0][PWM_W-1:0]  duty_q;
   logic [NUM_FANS-1:0]             auto_q;
   logic [NUM_FANS-1:0]             smooth_q;

   logic [1:0] slot;
   logic [1:0] field;
   assign slot  = addr[3:2];
   assign field = addr[1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         main_q   <= '0;
         duty_q   <= '0;
         auto_q   <= '0;
         smooth_q <= '0;
      end else if (wr_en) begin
         if (slot == 2'd0) begin
            if (field == 2'd0) ctrl_q <= ctrl_t'(wdata);
            if (field == 2'd1) main_q <= wdata & MAIN_MASK;
         end
         for (int i = 0; i < NUM_FANS; i++) begin
            if (slot == 2'(i + 1)) begin
               case (field)
                  2'd0:    duty_q[i]   <= wdata[PWM_W-1:0];
                  2'd1:    auto_q[i]   <= wdata[REG_W-1];
                  2'd2:    smooth_q[i] <= wdata[REG_W-1];
                  default: ;
               endcase
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (slot == 2'd0) begin
         if (field == 2'd0) rdata = REG_W'(ctrl_q);
         if (field == 2'd1) rdata = main_q;
      end
      for (int i = 0; i < NUM_FANS; i++) begin
         if (slot == 2'(i + 1)) begin
            case (field)
               2'd0:    rdata = REG_W'(duty_q[i]);
               2'd1:    rdata = {auto_q[i], {(REG_W-1){1'b0}}};
               2'd2:    rdata = {smooth_q[i], {(REG_W-1){1'b0}}};
               default: rdata = '0;
            endcase
         end
      end
   end

   assign pol     = ctrl_q.pol;
   assign clk_sel = ctrl_q.clk_sel;
   assign fan_en  = ctrl_q.fan_en[NUM_FANS-1:0];
   assign auto_md = auto_q;
   assign duty    = duty_q;

endmodule

// File: rtl/fanpwm_timebase.sv
module fanpwm_timebase
   import fanpwm_pkg::*;
#(
   parameter int PWM_W    = 8,
   parameter int SLOW_DIV = 940,
   localparam int DIV_W   = $clog2(SLOW_DIV + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       clk_sel,
   output logic [PWM_W-1:0] pwm_cnt,
   output logic             tick,
   output logic             bnd,
   output logic [DIV_W-1:0] div_now
);

   logic [DIV_W-1:0] div_cnt;

   assign tick = (div_cnt == div_now - DIV_W'(1));
   assign bnd  = tick && (&pwm_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         pwm_cnt <= '0;
         div_now <= DIV_W'(1);
      end else begin
         if (tick) begin
            div_cnt <= '0;
            pwm_cnt <= pwm_cnt + PWM_W'(1);
         end else begin
            div_cnt <= div_cnt + DIV_W'(1);
         end
         if (bnd)
            div_now <= DIV_W'(div_for_code(clk_sel, SLOW_DIV));
      end
   end

endmodule

// File: rtl/fanpwm_chan.sv
module fanpwm_chan #(
   parameter int PWM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bnd,
   input  logic [PWM_W-1:0] pwm_cnt,
   input  logic [PWM_W-1:0] duty,
   input  logic             en,
   input  logic             auto_md,
   input  logic             pol,
   output logic [PWM_W-1:0] duty_now,
   output logic             pwm_o
);

   logic drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   duty_now <= '0;
      else if (bnd) duty_now <= duty;
   end

   assign drive = en && !auto_md && (pwm_cnt < duty_now);
   assign pwm_o = pol ? drive : !drive;

endmodule

// File: rtl/fanpwm_top.sv
module fanpwm_top
   import fanpwm_pkg::*;
#(
   parameter int NUM_FANS = 3,
   parameter int PWM_W    = 8,
   parameter int SLOW_DIV = 940
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [REG_W-1:0]    wdata,
   output logic [REG_W-1:0]    rdata,
   output logic [NUM_FANS-1:0] pwm_o
);

   localparam int DIV_W = $clog2(SLOW_DIV + 1);

   if (NUM_FANS < 1 || NUM_FANS > 3) begin : g_bad_fans
      $error("NUM_FANS must be 1..3");
   end
   if (PWM_W < 4 || PWM_W > REG_W) begin : g_bad_width
      $error("PWM_W must be 4..8");
   end
   if (SLOW_DIV < 33) begin : g_bad_div
      $error("SLOW_DIV must exceed the largest fixed divisor");
   end

   logic                           pol;
   logic [2:0]                     clk_sel;
   logic [NUM_FANS-1:0]            fan_en;
   logic [NUM_FANS-1:0]            auto_md;
   logic [NUM_FANS-1:0][PWM_W-1:0] duty;
   logic [NUM_FANS-1:0][PWM_W-1:0] duty_now;
   logic [PWM_W-1:0]               pwm_cnt;
   logic                           tick;
   logic                           bnd;
   logic [DIV_W-1:0]               div_now;

   fanpwm_regs #(.NUM_FANS(NUM_FANS), .PWM_W(PWM_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .pol     (pol),
      .clk_sel (clk_sel),
      .fan_en  (fan_en),
      .auto_md (auto_md),
      .duty    (duty)
   );

   fanpwm_timebase #(.PWM_W(PWM_W), .SLOW_DIV(SLOW_DIV)) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_sel (clk_sel),
      .pwm_cnt (pwm_cnt),
      .tick    (tick),
      .bnd     (bnd),
      .div_now (div_now)
   );

   for (genvar g = 0; g < NUM_FANS; g++) begin : g_ch
      fanpwm_chan #(.PWM_W(PWM_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .bnd      (bnd),
         .pwm_cnt  (pwm_cnt),
         .duty     (duty[g]),
         .en       (fan_en[g]),
         .auto_md  (auto_md[g]),
         .pol      (pol),
         .duty_now (duty_now[g]),
         .pwm_o    (pwm_o[g])
      );
   end

endmodule

// File: rtl/fanpwm_chk.sv
module fanpwm_chk #(
   parameter int NUM_FANS = 3,
   parameter int PWM_W    = 8,
   parameter int DIV_W    = 10
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           pol,
   input logic [NUM_FANS-1:0]            fan_en,
   input logic [NUM_FANS-1:0]            auto_md,
   input logic [NUM_FANS-1:0][PWM_W-1:0] duty_now,
   input logic [NUM_FANS-1:0]            pwm_o,
   input logic [PWM_W-1:0]               pwm_cnt,
   input logic                           tick,
   input logic                           bnd,
   input logic [DIV_W-1:0]               div_now
);

   assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(pwm_cnt));

   assert_cnt_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bnd |=> (pwm_cnt == '0));

   assert_div_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(div_now));

   for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
      assert_duty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !bnd |=> $stable(duty_now[g]));

      assert_off_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !fan_en[g] |-> (pwm_o[g] == !pol));

      assert_auto_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         auto_md[g] |-> (pwm_o[g] == !pol));

      assert_zero_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (duty_now[g] == '0) |-> (pwm_o[g] == !pol));
   end

endmodule

bind fanpwm_top fanpwm_chk #(
   .NUM_FANS (NUM_FANS),
   .PWM_W    (PWM_W),
   .DIV_W    ($clog2(SLOW_DIV + 1))
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pol      (pol),
   .fan_en   (fan_en),
   .auto_md  (auto_md),
   .duty_now (duty_now),
   .pwm_o    (pwm_o),
   .pwm_cnt  (pwm_cnt),
   .tick     (tick),
   .bnd      (bnd),
   .div_now  (div_now)
);

// File: tb/sim_fanpwm_top.sv
`timescale 1ns/1ps
module sim_fanpwm_top;

   localparam int SLOW = 40;
   localparam int PER  = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [2:0] pwm_o;

   int n_chk  = 0;
   int n_fail = 0;
   int n_push = 0;
   int n_done = 0;
   int cur_per = PER;

   typedef struct {
      int    exp0;
      int    exp1;
      int    exp2;
      int    win;
      bit    act_hi;
      string tag;
   } item_t;

   item_t sb_q[$];

   always #2 clk = ~clk;

   fanpwm_top #(.NUM_FANS(3), .PWM_W(8), .SLOW_DIV(SLOW)) u0 (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .pwm_o (pwm_o)
   );

   function automatic int div_of(input int code);
      case (code)
         0:       return 1;
         1, 2:    return 2;
         3:       return 6;
         4:       return 8;
         5:       return 16;
         6:       return 32;
         default: return SLOW;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a;
      #1;
      chk(rdata == exp, tag, rdata, exp);
   endtask

   task automatic expect_win(input int e0, input int e1, input int e2,
                             input int win, input bit act_hi, input string tag);
      item_t it;
      it.exp0 = e0; it.exp1 = e1; it.exp2 = e2;
      it.win = win; it.act_hi = act_hi; it.tag = tag;
      sb_q.push_back(it);
      n_push++;
      wait (n_done == n_push);
   endtask

   task automatic settle(input int new_per);
      repeat (cur_per + new_per + 4) @(negedge clk);
      cur_per = new_per;
   endtask

   // monitor: counts active cycles per fan over one window and compares
   initial begin
      forever begin
         item_t it;
         int c0, c1, c2;
         wait (sb_q.size() > 0);
         it = sb_q.pop_front();
         c0 = 0; c1 = 0; c2 = 0;
         for (int k = 0; k < it.win; k++) begin
            @(negedge clk);
            if (pwm_o[0] == it.act_hi) c0++;
            if (pwm_o[1] == it.act_hi) c1++;
            if (pwm_o[2] == it.act_hi) c2++;
         end
         chk(c0 == it.exp0, {it.tag, " fan1"}, c0, it.exp0);
         chk(c1 == it.exp1, {it.tag, " fan2"}, c1, it.exp1);
         chk(c2 == it.exp2, {it.tag, " fan3"}, c2, it.exp2);
         n_done++;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(pwm_o == 3'b111, "R1 outputs during reset", pwm_o, 7);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(pwm_o == 3'b111, "R1 outputs after reset", pwm_o, 7);
      reg_rd(4'h0, 8'h00, "R1 control byte");
      reg_rd(4'h4, 8'h00, "R1 fan1 duty");

      // R2: register map and masking
      reg_wr(4'h1, 8'hFF);
      reg_rd(4'h1, 8'h77, "R2 smart/tach byte mask");
      reg_wr(4'h5, 8'hFF);
      reg_rd(4'h5, 8'h80, "R2 fan1 mode byte mask");
      reg_wr(4'h5, 8'h00);
      reg_wr(4'hA, 8'hFF);
      reg_rd(4'hA, 8'h80, "R2 fan2 smoothing byte mask");
      reg_wr(4'hC, 8'hA5);
      reg_rd(4'hC, 8'hA5, "R2 fan3 duty readback");
      reg_rd(4'h3, 8'h00, "R2 unmapped slot0 address");
      reg_rd(4'h7, 8'h00, "R2 unmapped fan1 address");

      // R3, R4, R10: active high, divisor 1, min-duty flag and smoothing set
      reg_wr(4'h4, 8'h80);
      reg_wr(4'h8, 8'h00);
      reg_wr(4'hC, 8'hFF);
      reg_wr(4'h0, 8'h8F);
      reg_rd(4'h0, 8'h8F, "R2 control byte readback");
      settle(PER);
      expect_win(128, 0, 255, PER, 1'b1, "R4 R10 duty 0x80/0x00/0xFF");

      // R5: active low
      reg_wr(4'h4, 8'h40);
      reg_wr(4'h8, 8'h01);
      reg_wr(4'hC, 8'hC0);
      reg_wr(4'h0, 8'h07);
      settle(PER);
      expect_win(64, 1, 192, PER, 1'b0, "R5 active-low duty");

      // R6: enable clear, immediate and steady
      reg_wr(4'h4, 8'h40);
      reg_wr(4'h8, 8'h40);
      reg_wr(4'hC, 8'h40);
      reg_wr(4'h0, 8'h87);
      settle(PER);
      reg_wr(4'h0, 8'h80);
      chk(pwm_o == 3'b000, "R6 outputs idle right after disable", pwm_o, 0);
      reg_wr(4'h0, 8'h85);
      settle(PER);
      expect_win(64, 0, 64, PER, 1'b1, "R6 fan2 disabled");

      // R7: automatic mode bit forces idle
      reg_wr(4'h0, 8'h87);
      reg_wr(4'hD, 8'h80);
      settle(PER);
      expect_win(64, 64, 0, PER, 1'b1, "R7 fan3 automatic");
      reg_wr(4'hD, 8'h00);

      // R8, R3: every non-zero clock-select code
      reg_wr(4'h4, 8'h80);
      reg_wr(4'h8, 8'h10);
      reg_wr(4'hC, 8'h01);
      for (int code = 1; code < 8; code++) begin
         int d;
         d = div_of(code);
         reg_wr(4'h0, 8'h87 | 8'(code << 4));
         settle(PER * d);
         expect_win(128 * d, 16 * d, d, PER * d, 1'b1,
                    $sformatf("R8 R3 clock code %0d", code));
      end
      reg_wr(4'h0, 8'h87);
      settle(PER);

      // R9: duty rewrite mid-period is deferred to the boundary
      reg_wr(4'h4, 8'h32);
      settle(PER);
      begin
         logic prev;
         int   hits;
         int   guard;
         prev  = pwm_o[0];
         guard = 0;
         forever begin
            @(negedge clk);
            guard++;
            if (!prev && pwm_o[0]) break;
            if (guard > 2 * PER) break;
            prev = pwm_o[0];
         end
         repeat (100) @(negedge clk);
         reg_wr(4'h4, 8'hC8);
         hits = 0;
         for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (pwm_o[0]) hits++;
         end
         chk(hits == 0, "R9 no pulse before boundary after duty rewrite", hits, 0);
      end
      settle(PER);
      expect_win(200, 16, 1, PER, 1'b1, "R9 new duty after boundary");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule